// File: doc/BRIEF.md
# HE Control Word Composer

This block assembles the 32-bit HT/HE control word that goes into one outgoing frame. It first takes one of five per-bandwidth base words, picked by a bandwidth code. It can then apply a bit-masked overwrite whose data comes from a bank of sixteen registers. A 4-bit index chooses the register, and which index applies depends on the kind of response being sent. Last, it places up to three tagged control subfields at programmable bit offsets: a power-headroom report for trigger responses, a buffer-status report for buffer-status-poll responses, and a coordination subfield during a spatial-reuse window.

The inputs are presented together with a one-cycle `start` strobe. A two-stage pipeline returns the composed word with a `done` pulse. The overwrite bank is loaded through a plain write port. A sticky flag records any request that asked for an insertion at an offset outside the legal range.

Top module: `he_ctrl_composer`

## Requirements
- R1: After reset, `done` is 0, `ctrl_word` is 0 and `off_err` is 0.
- R2: `bw_code` selects the base word: 0 gives `base_w20`, 1 `base_w40`, 2 `base_w80`, 3 `base_w160` and 4 `base_w320`. Codes 5 to 7 fall back to `base_w20`.
- R3: When `ovr_en` is 1, each bit set in `ovr_mask` takes its value from overwrite register `idx`, and all other bits keep their base value. `idx` is `ovr_idx_bsrp` if `is_bsrp_resp` is 1 (also inside a spatial-reuse window). Otherwise it is `ovr_idx_sr` if `in_sr_window` is 1, and `ovr_idx` in all other cases. When `ovr_en` is 0, no bit is overwritten.
- R4: When `uph_en` and `is_trig_resp` are both 1, 12 bits starting at bit `uph_off` are written, LSB first: control ID 4 (4 bits), then `uph_info` (6 bits), then `uph_hi` (2 bits).
- R5: When `bqr_en` and `is_bsrp_resp` are both 1, 14 bits starting at bit `bqr_off` are written: control ID 5, then `bqr_info` (8 bits), then `bqr_hi` (2 bits). Bits that would land above bit 31 are dropped.
- R6: When `cas_en` and `in_sr_window` are both 1, 12 bits starting at bit `cas_off` are written: control ID 6, then `cas_info` (8 bits).
- R7: The steps apply in the order overwrite, power headroom, buffer status, coordination, and a later step wins on any bit it covers. If the coordination insertion is active and `cas_off` equals `bqr_off`, the whole buffer-status insertion is skipped.
- R8: An insertion whose offset is below 2 or above 20 is not performed. If its enable bit is 1 at `start`, `off_err` becomes 1 and stays 1 until reset.
- R9: Bits [1:0] of every composed word are 2'b11.
- R10: `done` is high for exactly the one cycle that comes two cycles after the cycle in which `start` is sampled high, and `ctrl_word` carries the result in that cycle. `ctrl_word` then holds that value until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the overwrite bank |
| cfg_waddr | input | 4 | Bank entry to write |
| cfg_wdata | input | 32 | Data written to the bank |
| start | input | 1 | Starts one composition; all other inputs are sampled with it |
| bw_code | input | 3 | Bandwidth code |
| base_w20 | input | 32 | Base word, 20 MHz |
| base_w40 | input | 32 | Base word, 40 MHz |
| base_w80 | input | 32 | Base word, 80 MHz |
| base_w160 | input | 32 | Base word, 160 MHz |
| base_w320 | input | 32 | Base word, 320 MHz |
| ovr_en | input | 1 | Enables the masked overwrite |
| ovr_mask | input | 32 | Bits to overwrite |
| ovr_idx | input | 4 | Bank index for the general case |
| ovr_idx_sr | input | 4 | Bank index inside a spatial-reuse window |
| ovr_idx_bsrp | input | 4 | Bank index for buffer-status-poll responses |
| is_trig_resp | input | 1 | The frame answers a trigger |
| is_bsrp_resp | input | 1 | The frame answers a buffer-status poll |
| in_sr_window | input | 1 | A spatial-reuse window is open |
| uph_en | input | 1 | Power-headroom insertion enable |
| uph_off | input | 5 | Power-headroom start bit |
| uph_info | input | 6 | Headroom value |
| uph_hi | input | 2 | Upper two headroom bits |
| bqr_en | input | 1 | Buffer-status insertion enable |
| bqr_off | input | 5 | Buffer-status start bit |
| bqr_info | input | 8 | Buffer-status value |
| bqr_hi | input | 2 | Upper two buffer-status bits |
| cas_en | input | 1 | Coordination insertion enable |
| cas_off | input | 5 | Coordination start bit |
| cas_info | input | 8 | Coordination value |
| ctrl_word | output | 32 | Composed control word |
| done | output | 1 | Result valid, one-cycle pulse |
| off_err | output | 1 | Sticky illegal-offset flag |

## Verification
The hardest case to reach from the ports is the conflict rule: the buffer-status insertion is dropped only if a buffer-status-poll response and an open spatial-reuse window coincide, both insertions are enabled, and both use the same legal offset. Random offsets almost never line up. The bench therefore forces that alignment in directed vectors, including the edge offset 20, where the buffer-status field would also be truncated. It also drives a near miss one bit apart, where both fields must appear and overlap.

// File: rtl/he_ctrl_composer.sv
module he_ctrl_composer #(
  parameter int N_OVR = 16,
  localparam int IW = $clog2(N_OVR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_waddr,
  input  logic [31:0]   cfg_wdata,
  input  logic          start,
  input  logic [2:0]    bw_code,
  input  logic [31:0]   base_w20,
  input  logic [31:0]   base_w40,
  input  logic [31:0]   base_w80,
  input  logic [31:0]   base_w160,
  input  logic [31:0]   base_w320,
  input  logic          ovr_en,
  input  logic [31:0]   ovr_mask,
  input  logic [IW-1:0] ovr_idx,
  input  logic [IW-1:0] ovr_idx_sr,
  input  logic [IW-1:0] ovr_idx_bsrp,
  input  logic          is_trig_resp,
  input  logic          is_bsrp_resp,
  input  logic          in_sr_window,
  input  logic          uph_en,
  input  logic [4:0]    uph_off,
  input  logic [5:0]    uph_info,
  input  logic [1:0]    uph_hi,
  input  logic          bqr_en,
  input  logic [4:0]    bqr_off,
  input  logic [7:0]    bqr_info,
  input  logic [1:0]    bqr_hi,
  input  logic          cas_en,
  input  logic [4:0]    cas_off,
  input  logic [7:0]    cas_info,
  output logic [31:0]   ctrl_word,
  output logic          done,
  output logic          off_err
);

  localparam logic [3:0] ID_UPH = 4'd4;
  localparam logic [3:0] ID_BQR = 4'd5;
  localparam logic [3:0] ID_CAS = 4'd6;
  localparam logic [4:0] OFF_MIN = 5'd2;
  localparam logic [4:0] OFF_MAX = 5'd20;

  function automatic logic in_range(input logic [4:0] off);
    return (off >= OFF_MIN) && (off <= OFF_MAX);
  endfunction

  function automatic logic [31:0] put_field(input logic [31:0] w, input logic [31:0] val,
                                            input logic [31:0] msk, input logic [4:0] off);
    logic [31:0] m;
    m = msk << off;
    return (w & ~m) | ((val << off) & m);
  endfunction

  logic [31:0] ovr_bank [N_OVR];

  always_ff @(posedge clk)
    if (cfg_we) ovr_bank[cfg_waddr] <= cfg_wdata;

  logic [31:0]   base_sel, ovr_word;
  logic [IW-1:0] idx_sel;
  logic          uph_go, bqr_go, cas_go, bad_off;

  always_comb begin
    case (bw_code)
      3'd1:    base_sel = base_w40;
      3'd2:    base_sel = base_w80;
      3'd3:    base_sel = base_w160;
      3'd4:    base_sel = base_w320;
      default: base_sel = base_w20;
    endcase
  end

  assign idx_sel  = is_bsrp_resp ? ovr_idx_bsrp : (in_sr_window ? ovr_idx_sr : ovr_idx);
  assign ovr_word = ovr_en ? ((base_sel & ~ovr_mask) | (ovr_bank[idx_sel] & ovr_mask)) : base_sel;

  assign uph_go  = uph_en && is_trig_resp && in_range(uph_off);
  assign cas_go  = cas_en && in_sr_window && in_range(cas_off);
  assign bqr_go  = bqr_en && is_bsrp_resp && in_range(bqr_off) && !(cas_go && cas_off == bqr_off);
  assign bad_off = (uph_en && !in_range(uph_off)) || (bqr_en && !in_range(bqr_off)) ||
                   (cas_en && !in_range(cas_off));

  logic        s1_vld, s1_uph, s1_bqr, s1_cas;
  logic [31:0] s1_word;
  logic [4:0]  s1_uph_off, s1_bqr_off, s1_cas_off;
  logic [11:0] s1_uph_pay, s1_cas_pay;
  logic [13:0] s1_bqr_pay;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0; s1_uph <= 1'b0; s1_bqr <= 1'b0; s1_cas <= 1'b0;
      s1_word <= '0; s1_uph_off <= '0; s1_bqr_off <= '0; s1_cas_off <= '0;
      s1_uph_pay <= '0; s1_bqr_pay <= '0; s1_cas_pay <= '0;
      off_err <= 1'b0;
    end else begin
      s1_vld <= start;
      if (start) begin
        s1_word    <= ovr_word;
        s1_uph     <= uph_go;
        s1_bqr     <= bqr_go;
        s1_cas     <= cas_go;
        s1_uph_off <= uph_off;
        s1_bqr_off <= bqr_off;
        s1_cas_off <= cas_off;
        s1_uph_pay <= {uph_hi, uph_info, ID_UPH};
        s1_bqr_pay <= {bqr_hi, bqr_info, ID_BQR};
        s1_cas_pay <= {cas_info, ID_CAS};
        if (bad_off) off_err <= 1'b1;
      end
    end
  end

  logic [31:0] w_uph, w_bqr, w_cas;

  assign w_uph = s1_uph ? put_field(s1_word, {20'd0, s1_uph_pay}, 32'h0000_0FFF, s1_uph_off) : s1_word;
  assign w_bqr = s1_bqr ? put_field(w_uph, {18'd0, s1_bqr_pay}, 32'h0000_3FFF, s1_bqr_off) : w_uph;
  assign w_cas = s1_cas ? put_field(w_bqr, {20'd0, s1_cas_pay}, 32'h0000_0FFF, s1_cas_off) : w_bqr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_word <= '0;
      done      <= 1'b0;
    end else begin
      done <= s1_vld;
      if (s1_vld) ctrl_word <= {w_cas[31:2], 2'b11};
    end
  end

  assert_stage1_follows_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> s1_vld);
  assert_done_follows_stage1_R10: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> done);
  assert_word_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> $stable(ctrl_word));
  assert_he_marker_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ctrl_word[1:0] == 2'b11);
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    off_err |=> off_err);

endmodule

// File: tb/he_ctrl_composer_tb.sv
module he_ctrl_composer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cfg_we = 0; logic [3:0] cfg_waddr = 0; logic [31:0] cfg_wdata = 0;
  logic start = 0; logic [2:0] bw_code = 0;
  logic [31:0] base_w20 = 0, base_w40 = 0, base_w80 = 0, base_w160 = 0, base_w320 = 0;
  logic ovr_en = 0; logic [31:0] ovr_mask = 0;
  logic [3:0] ovr_idx = 0, ovr_idx_sr = 0, ovr_idx_bsrp = 0;
  logic is_trig_resp = 0, is_bsrp_resp = 0, in_sr_window = 0;
  logic uph_en = 0; logic [4:0] uph_off = 0; logic [5:0] uph_info = 0; logic [1:0] uph_hi = 0;
  logic bqr_en = 0; logic [4:0] bqr_off = 0; logic [7:0] bqr_info = 0; logic [1:0] bqr_hi = 0;
  logic cas_en = 0; logic [4:0] cas_off = 0; logic [7:0] cas_info = 0;
  logic [31:0] ctrl_word; logic done, off_err;

  he_ctrl_composer dut_i (.*);

  int n_chk = 0, n_bad = 0;
  logic [31:0] bank_m [16];
  logic exp_err = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] place(input logic [31:0] w, input logic [31:0] val,
                                        input int width, input int off);
    logic [31:0] r = w;
    for (int i = 0; i < 32; i++)
      if (i >= off && i - off < width) r[i] = val[i - off];
    return r;
  endfunction

  function automatic bit legal(input logic [4:0] o);
    return o >= 2 && o <= 20;
  endfunction

  function automatic logic [31:0] model();
    logic [31:0] w; logic [3:0] ix; bit cg, bg;
    case (bw_code)
      3'd1: w = base_w40; 3'd2: w = base_w80; 3'd3: w = base_w160;
      3'd4: w = base_w320; default: w = base_w20;
    endcase
    ix = is_bsrp_resp ? ovr_idx_bsrp : in_sr_window ? ovr_idx_sr : ovr_idx;
    if (ovr_en)
      for (int i = 0; i < 32; i++) if (ovr_mask[i]) w[i] = bank_m[ix][i];
    if (uph_en && is_trig_resp && legal(uph_off))
      w = place(w, {20'd0, uph_hi, uph_info, 4'd4}, 12, int'(uph_off));
    cg = cas_en && in_sr_window && legal(cas_off);
    bg = bqr_en && is_bsrp_resp && legal(bqr_off) && !(cg && cas_off == bqr_off);
    if (bg) w = place(w, {18'd0, bqr_hi, bqr_info, 4'd5}, 14, int'(bqr_off));
    if (cg) w = place(w, {20'd0, cas_info, 4'd6}, 12, int'(cas_off));
    w[1:0] = 2'b11;
    return w;
  endfunction

  task automatic run_vec(input string req);
    logic [31:0] e, held;
    e = model();
    if ((uph_en && !legal(uph_off)) || (bqr_en && !legal(bqr_off)) || (cas_en && !legal(cas_off)))
      exp_err = 1;
    start = 1;
    @(negedge clk); start = 0;
    check({req, " R10 done early"}, {31'd0, done}, 32'd0);
    @(negedge clk);
    check({req, " R10 done"}, {31'd0, done}, 32'd1);
    check(req, ctrl_word, e);
    check({req, " R9 marker"}, {30'd0, ctrl_word[1:0]}, 32'd3);
    check({req, " R8 off_err"}, {31'd0, off_err}, {31'd0, exp_err});
    held = ctrl_word;
    @(negedge clk);
    check({req, " R10 single pulse"}, {31'd0, done}, 32'd0);
    check({req, " R10 held"}, ctrl_word, held);
  endtask

  task automatic clear_cfg();
    ovr_en = 0; is_trig_resp = 0; is_bsrp_resp = 0; in_sr_window = 0;
    uph_en = 0; bqr_en = 0; cas_en = 0; bw_code = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 word", ctrl_word, 32'd0);
    check("R1 err", {31'd0, off_err}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      cfg_we = 1; cfg_waddr = 4'(i); cfg_wdata = $urandom; bank_m[i] = cfg_wdata;
      @(negedge clk);
    end
    cfg_we = 0;
    base_w20 = 32'h1111_1110; base_w40 = 32'h2222_2220; base_w80 = 32'h4444_4440;
    base_w160 = 32'h8888_8880; base_w320 = 32'hF0F0_F0F0;
    for (int b = 0; b < 8; b++) begin
      clear_cfg(); bw_code = 3'(b);
      run_vec("R2 base select");
    end
    clear_cfg(); ovr_en = 1; ovr_mask = 32'h00FF_FF00;
    ovr_idx = 1; ovr_idx_sr = 2; ovr_idx_bsrp = 3;
    run_vec("R3 general index");
    in_sr_window = 1; run_vec("R3 sr index");
    is_bsrp_resp = 1; run_vec("R3 bsrp index wins in sr window");
    clear_cfg(); ovr_mask = 32'hFFFF_FFFF; ovr_idx = 5;
    run_vec("R3 overwrite disabled");
    clear_cfg(); uph_en = 1; uph_off = 5'd7; uph_info = 6'h2A; uph_hi = 2'b10;
    run_vec("R4 uph needs trigger");
    is_trig_resp = 1; run_vec("R4 uph insert");
    clear_cfg(); is_bsrp_resp = 1; bqr_en = 1; bqr_off = 5'd20; bqr_info = 8'hC3; bqr_hi = 2'b11;
    run_vec("R5 bqr truncated at 20");
    bqr_off = 5'd2; run_vec("R5 bqr at 2");
    clear_cfg(); cas_en = 1; cas_off = 5'd12; cas_info = 8'h5A;
    run_vec("R6 cas outside window");
    in_sr_window = 1; run_vec("R6 cas insert");
    is_bsrp_resp = 1; bqr_en = 1; bqr_off = 5'd12;
    run_vec("R7 conflict drops bqr");
    cas_off = 5'd20; bqr_off = 5'd20; run_vec("R7 conflict at 20");
    bqr_off = 5'd19; run_vec("R7 near miss overlap");
    is_trig_resp = 1; uph_en = 1; uph_off = 5'd14; run_vec("R7 order all three");
    clear_cfg(); uph_en = 1; is_trig_resp = 1; uph_off = 5'd1;
    run_vec("R8 offset 1 disables");
    uph_off = 5'd21; run_vec("R8 offset 21 disables");
    clear_cfg(); run_vec("R8 err sticky");
    for (int n = 0; n < 300; n++) begin
      bw_code = 3'($urandom_range(0, 7));
      base_w20 = $urandom; base_w40 = $urandom; base_w80 = $urandom;
      base_w160 = $urandom; base_w320 = $urandom;
      ovr_en = 1'($urandom); ovr_mask = $urandom;
      ovr_idx = 4'($urandom); ovr_idx_sr = 4'($urandom); ovr_idx_bsrp = 4'($urandom);
      is_trig_resp = 1'($urandom); is_bsrp_resp = 1'($urandom); in_sr_window = 1'($urandom);
      uph_en = 1'($urandom); uph_info = 6'($urandom); uph_hi = 2'($urandom);
      bqr_en = 1'($urandom); bqr_info = 8'($urandom); bqr_hi = 2'($urandom);
      cas_en = 1'($urandom); cas_info = 8'($urandom);
      uph_off = ($urandom_range(0, 15) == 0) ? 5'($urandom) : 5'($urandom_range(2, 20));
      bqr_off = ($urandom_range(0, 15) == 0) ? 5'($urandom) : 5'($urandom_range(2, 20));
      cas_off = ($urandom_range(0, 3) == 0) ? bqr_off : 5'($urandom_range(2, 20));
      run_vec("R2-mix random R3 R4 R5 R6 R7");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule